// File: doc/BRIEF.md
# Peripheral Quadrant Write-Protection Checker

This block sits beside the peripheral bus and decides, for each write, whether the target region may be written. The peripheral register space is made of peripheral-select frames of 1 KB. Each frame is cut into four 256-byte quadrants. A protection register holds one bit per quadrant. The bit index is four times the frame number plus the quadrant number. A peripheral that covers two or four quadrants is governed only by the bit of its first quadrant. The other bits of that span do not exist: they always read 0 and ignore writes. The span of every frame is fixed at build time by a parameter. A second register holds one protection bit per peripheral memory frame.

Software sets protection bits through a set port and removes them through a clear port. Both ports take a mask of ones. A protected region accepts writes only from privileged-mode accesses. An unprotected region accepts writes in any mode. When a user-mode write lands in a protected region, the block raises a one-cycle abort pulse in the cycle after the request and records the address of that write.

Top module: `quad_write_guard`

## Requirements
- R1: After reset every quadrant bit and every memory-frame bit is 0 (unprotected), the abort output is 0 and the recorded fault address is 0.
- R2: Writing a mask to the quadrant set port sets every implemented bit that has a 1 in the mask. Bits with a 0 in the mask keep their value.
- R3: Writing a mask to the quadrant clear port clears every bit that has a 1 in the mask. A zero mask changes nothing. If set and clear arrive in the same cycle, clear wins for the bits both masks name.
- R4: Bits that are not implemented always read 0 and ignore set writes. For a two-quadrant frame these are the quadrant 1 and quadrant 3 bits. For a four-quadrant frame these are the quadrant 1, 2 and 3 bits.
- R5: In a register-space write, address bits [9:8] pick the quadrant and bits [11:10] pick the frame (default of four frames). A single-quadrant frame is governed by bit 4*frame+quadrant.
- R6: In a two-quadrant frame, quadrants 0 and 1 are both governed by the quadrant 0 bit, and quadrants 2 and 3 are both governed by the quadrant 2 bit.
- R7: In a four-quadrant frame, all four quadrants are governed by the quadrant 0 bit.
- R8: A user-mode write to a protected region produces an abort pulse that is high in exactly the cycle after the request.
- R9: Privileged writes, reads in any mode, and writes to unprotected regions never produce an abort.
- R10: On each abort the address of the offending write is recorded. The recorded address does not change while no abort occurs.
- R11: In a memory-space access (memory select high), address bits [13:12] pick one of four memory frames. That frame's bit, set and cleared through its own set and clear ports with 4-bit masks, governs writes in the same way as the quadrant bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| quadSetWe | input | 1 | Apply quadWdata as a set mask |
| quadClrWe | input | 1 | Apply quadWdata as a clear mask |
| quadWdata | input | 16 | Quadrant bit mask |
| memSetWe | input | 1 | Apply memWdata as a set mask |
| memClrWe | input | 1 | Apply memWdata as a clear mask |
| memWdata | input | 4 | Memory-frame bit mask |
| quadProt | output | 16 | Current quadrant protection state |
| memProt | output | 4 | Current memory-frame protection state |
| busValid | input | 1 | Bus access request |
| busWrite | input | 1 | 1 = write, 0 = read |
| busPriv | input | 1 | 1 = privileged mode |
| busMem | input | 1 | 1 = memory-frame space, 0 = register space |
| busAddr | input | 16 | Access address |
| abortPulse | output | 1 | Registered violation pulse |
| faultAddr | output | 16 | Address of the last violating write |

## Verification
A wrong protection bit shows up at the quadProt or memProt outputs one cycle after the set or clear write that caused it. It also shows up on abortPulse, in the cycle after the first user-mode write that reaches the affected region. A wrong folding or decode is only visible through abortPulse. That is why the stimulus writes to every quadrant position of the one-, two- and four-quadrant frames, with the governing bit both set and cleared. A wrong fault-address capture appears on faultAddr in the same cycle as the abort pulse.

// File: rtl/quad_guard_pkg.sv
package quad_guard_pkg;

  localparam int QUAD_LSB     = 8;
  localparam int PS_LSB       = 10;
  localparam int QUADS_PER_PS = 4;

  typedef enum logic [1:0] {
    SPAN_ONE  = 2'd0,
    SPAN_TWO  = 2'd1,
    SPAN_FOUR = 2'd2
  } spanT;

  typedef struct packed {
    logic setQuad;
    logic clrQuad;
    logic setMem;
    logic clrMem;
    logic capture;
  } strobeT;

  // quadrant whose bit governs quadrant q under the given span
  function automatic int ownerQuad(input logic [1:0] span, input int q);
    if (span == SPAN_ONE) return q;
    if (span == SPAN_TWO) return q & 2;
    return 0;
  endfunction

endpackage

// File: rtl/quad_guard_ctrl.sv
module quad_guard_ctrl
  import quad_guard_pkg::*;
(
  input  logic   clk,
  input  logic   rstN,
  input  logic   quadSetWe,
  input  logic   quadClrWe,
  input  logic   memSetWe,
  input  logic   memClrWe,
  input  logic   busValid,
  input  logic   busWrite,
  input  logic   busPriv,
  input  logic   regionProt,
  output strobeT stb,
  output logic   abortPulse
);

  logic violation;

  // only user-mode writes into protected space are illegal
  assign violation = busValid && busWrite && !busPriv && regionProt;

  always_comb begin
    stb         = '0;
    stb.setQuad = quadSetWe;
    stb.clrQuad = quadClrWe;
    stb.setMem  = memSetWe;
    stb.clrMem  = memClrWe;
    stb.capture = violation;
  end

  always_ff @(posedge clk) begin
    if (!rstN) abortPulse <= 1'b0;
    else       abortPulse <= violation;
  end

endmodule

// File: rtl/quad_guard_dp.sv
module quad_guard_dp
  import quad_guard_pkg::*;
#(
  parameter int NUM_PS    = 4,
  parameter int NUM_MEM   = 4,
  parameter int ADDR_W    = 16,
  parameter int MEM_SHIFT = 12,
  parameter logic [2*NUM_PS-1:0] PS_SPAN = 8'b10_01_00_00,
  localparam int NQ    = NUM_PS * QUADS_PER_PS,
  localparam int PS_W  = (NUM_PS > 1) ? $clog2(NUM_PS) : 1,
  localparam int MEM_W = (NUM_MEM > 1) ? $clog2(NUM_MEM) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobeT            stb,
  input  logic [NQ-1:0]     quadWdata,
  input  logic [NUM_MEM-1:0] memWdata,
  input  logic              busMem,
  input  logic [ADDR_W-1:0] busAddr,
  output logic              regionProt,
  output logic [NQ-1:0]     quadProt,
  output logic [NUM_MEM-1:0] memProt,
  output logic [ADDR_W-1:0] faultAddr
);

  logic [NQ-1:0]      quadReg;
  logic [NUM_MEM-1:0] memReg;
  logic [NQ-1:0]      implMask;
  logic [NQ-1:0]      govBits;

  // per-frame folding: a bit exists only where it governs itself
  for (genvar p = 0; p < NUM_PS; p++) begin : gPs
    for (genvar q = 0; q < QUADS_PER_PS; q++) begin : gQuad
      localparam int OWN = ownerQuad(PS_SPAN[2*p +: 2], q);
      assign implMask[QUADS_PER_PS*p + q] = (OWN == q);
      assign govBits[QUADS_PER_PS*p + q]  = quadReg[QUADS_PER_PS*p + OWN];
    end
  end

  logic [NQ-1:0] quadSetMask, quadClrMask;
  logic [NUM_MEM-1:0] memSetMask, memClrMask;

  assign quadSetMask = stb.setQuad ? quadWdata : '0;
  assign quadClrMask = stb.clrQuad ? quadWdata : '0;
  assign memSetMask  = stb.setMem  ? memWdata  : '0;
  assign memClrMask  = stb.clrMem  ? memWdata  : '0;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      quadReg <= '0;
      memReg  <= '0;
    end else begin
      quadReg <= ((quadReg | quadSetMask) & ~quadClrMask) & implMask;
      memReg  <= (memReg | memSetMask) & ~memClrMask;
    end
  end

  // address decode
  logic [PS_W-1:0]    psIdx;
  logic [1:0]         quadIdx;
  logic [MEM_W-1:0]   memIdx;
  logic               regHit, memHit;

  assign psIdx   = busAddr[PS_LSB +: PS_W];
  assign quadIdx = busAddr[QUAD_LSB +: 2];
  assign memIdx  = busAddr[MEM_SHIFT +: MEM_W];

  always_comb begin
    regHit = 1'b0;
    if (int'(psIdx) < NUM_PS) regHit = govBits[{psIdx, quadIdx}];
    memHit = 1'b0;
    if (int'(memIdx) < NUM_MEM) memHit = memReg[memIdx];
  end

  assign regionProt = busMem ? memHit : regHit;

  always_ff @(posedge clk) begin
    if (!rstN)           faultAddr <= '0;
    else if (stb.capture) faultAddr <= busAddr;
  end

  assign quadProt = quadReg;
  assign memProt  = memReg;

endmodule

// File: rtl/quad_write_guard.sv
module quad_write_guard
  import quad_guard_pkg::*;
#(
  parameter int NUM_PS    = 4,
  parameter int NUM_MEM   = 4,
  parameter int ADDR_W    = 16,
  parameter int MEM_SHIFT = 12,
  parameter logic [2*NUM_PS-1:0] PS_SPAN = 8'b10_01_00_00,
  localparam int NQ = NUM_PS * QUADS_PER_PS
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               quadSetWe,
  input  logic               quadClrWe,
  input  logic [NQ-1:0]      quadWdata,
  input  logic               memSetWe,
  input  logic               memClrWe,
  input  logic [NUM_MEM-1:0] memWdata,
  output logic [NQ-1:0]      quadProt,
  output logic [NUM_MEM-1:0] memProt,
  input  logic               busValid,
  input  logic               busWrite,
  input  logic               busPriv,
  input  logic               busMem,
  input  logic [ADDR_W-1:0]  busAddr,
  output logic               abortPulse,
  output logic [ADDR_W-1:0]  faultAddr
);

  strobeT stb;
  logic   regionProt;

  quad_guard_ctrl uCtrl (
    .clk        (clk),
    .rstN       (rstN),
    .quadSetWe  (quadSetWe),
    .quadClrWe  (quadClrWe),
    .memSetWe   (memSetWe),
    .memClrWe   (memClrWe),
    .busValid   (busValid),
    .busWrite   (busWrite),
    .busPriv    (busPriv),
    .regionProt (regionProt),
    .stb        (stb),
    .abortPulse (abortPulse)
  );

  quad_guard_dp #(
    .NUM_PS    (NUM_PS),
    .NUM_MEM   (NUM_MEM),
    .ADDR_W    (ADDR_W),
    .MEM_SHIFT (MEM_SHIFT),
    .PS_SPAN   (PS_SPAN)
  ) uDp (
    .clk        (clk),
    .rstN       (rstN),
    .stb        (stb),
    .quadWdata  (quadWdata),
    .memWdata   (memWdata),
    .busMem     (busMem),
    .busAddr    (busAddr),
    .regionProt (regionProt),
    .quadProt   (quadProt),
    .memProt    (memProt),
    .faultAddr  (faultAddr)
  );

endmodule

// File: rtl/quad_guard_chk.sv
module quad_guard_chk #(
  parameter int NUM_PS = 4,
  parameter int ADDR_W = 16,
  parameter logic [2*NUM_PS-1:0] PS_SPAN = 8'b10_01_00_00,
  localparam int NQ = NUM_PS * 4
) (
  input logic              clk,
  input logic              rstN,
  input logic              quadSetWe,
  input logic              quadClrWe,
  input logic [NQ-1:0]     quadWdata,
  input logic [NQ-1:0]     quadProt,
  input logic              busValid,
  input logic              busWrite,
  input logic              busPriv,
  input logic [ADDR_W-1:0] busAddr,
  input logic              abortPulse,
  input logic [ADDR_W-1:0] faultAddr
);

  function automatic logic [NQ-1:0] legalBits();
    logic [NQ-1:0] m;
    m = '0;
    for (int p = 0; p < NUM_PS; p++) begin
      case (PS_SPAN[2*p +: 2])
        2'd0:    m[4*p +: 4] = 4'b1111;
        2'd1:    m[4*p +: 4] = 4'b0101;
        default: m[4*p +: 4] = 4'b0001;
      endcase
    end
    return m;
  endfunction

  localparam logic [NQ-1:0] LEGAL = legalBits();

  // R2
  set_takes_chk: assert property (@(posedge clk) disable iff (!rstN)
    (quadSetWe && !quadClrWe) |=> ((quadProt & $past(quadWdata) & LEGAL) == ($past(quadWdata) & LEGAL)));

  // R3
  clear_takes_chk: assert property (@(posedge clk) disable iff (!rstN)
    quadClrWe |=> ((quadProt & $past(quadWdata)) == '0));

  // R4
  no_phantom_bits_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((quadProt & ~LEGAL) == '0));

  // R8
  abort_cause_chk: assert property (@(posedge clk) disable iff (!rstN)
    abortPulse |-> $past(busValid && busWrite && !busPriv));

  // R9
  allowed_access_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busValid && (!busWrite || busPriv)) |=> !abortPulse);

  // R10
  fault_addr_chk: assert property (@(posedge clk) disable iff (!rstN)
    abortPulse |-> (faultAddr == $past(busAddr)));

  // R10
  fault_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !abortPulse |-> $stable(faultAddr));

endmodule

bind quad_write_guard quad_guard_chk #(
  .NUM_PS  (NUM_PS),
  .ADDR_W  (ADDR_W),
  .PS_SPAN (PS_SPAN)
) uChk (
  .clk        (clk),
  .rstN       (rstN),
  .quadSetWe  (quadSetWe),
  .quadClrWe  (quadClrWe),
  .quadWdata  (quadWdata),
  .quadProt   (quadProt),
  .busValid   (busValid),
  .busWrite   (busWrite),
  .busPriv    (busPriv),
  .busAddr    (busAddr),
  .abortPulse (abortPulse),
  .faultAddr  (faultAddr)
);

// File: tb/sim_quad_write_guard.sv
module sim_quad_write_guard;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        quadSetWe = 0, quadClrWe = 0, memSetWe = 0, memClrWe = 0;
  logic [15:0] quadWdata = '0;
  logic [3:0]  memWdata = '0;
  logic [15:0] quadProt;
  logic [3:0]  memProt;
  logic        busValid = 0, busWrite = 0, busPriv = 0, busMem = 0;
  logic [15:0] busAddr = '0;
  logic        abortPulse;
  logic [15:0] faultAddr;

  int checkCnt = 0;
  int failCnt  = 0;

  always #5 clk = ~clk;

  quad_write_guard u0 (
    .clk(clk), .rstN(rstN),
    .quadSetWe(quadSetWe), .quadClrWe(quadClrWe), .quadWdata(quadWdata),
    .memSetWe(memSetWe), .memClrWe(memClrWe), .memWdata(memWdata),
    .quadProt(quadProt), .memProt(memProt),
    .busValid(busValid), .busWrite(busWrite), .busPriv(busPriv),
    .busMem(busMem), .busAddr(busAddr),
    .abortPulse(abortPulse), .faultAddr(faultAddr)
  );

  // kind: 0 idle, 1 quad set, 2 quad clear, 3 bus access, 4 mem set, 5 mem clear
  // fields: kind[58:56] data[55:40] addr[39:24] write priv mem [23:21]
  //         expAbort[20] expQuad[19:4] expMem[3:0]
  localparam int NV = 22;
  localparam logic [58:0] VEC [NV] = '{
    {3'd1, 16'hFFFF, 16'h0000, 3'b000, 1'b0, 16'h15FF, 4'h0}, // R2 R4
    {3'd2, 16'h00F0, 16'h0000, 3'b000, 1'b0, 16'h150F, 4'h0}, // R3
    {3'd2, 16'h0000, 16'h0000, 3'b000, 1'b0, 16'h150F, 4'h0}, // R3 zero mask
    {3'd1, 16'h0A00, 16'h0000, 3'b000, 1'b0, 16'h150F, 4'h0}, // R4 absent bits
    {3'd3, 16'h0000, 16'h0100, 3'b100, 1'b1, 16'h150F, 4'h0}, // R5 R8
    {3'd0, 16'h0000, 16'h0000, 3'b000, 1'b0, 16'h150F, 4'h0}, // R8 one cycle
    {3'd3, 16'h0000, 16'h0600, 3'b100, 1'b0, 16'h150F, 4'h0}, // R5 R9 open
    {3'd3, 16'h0000, 16'h0000, 3'b110, 1'b0, 16'h150F, 4'h0}, // R9 privileged
    {3'd3, 16'h0000, 16'h0000, 3'b000, 1'b0, 16'h150F, 4'h0}, // R9 read
    {3'd2, 16'h0100, 16'h0000, 3'b000, 1'b0, 16'h140F, 4'h0}, // R3
    {3'd3, 16'h0000, 16'h0900, 3'b100, 1'b0, 16'h140F, 4'h0}, // R6 lower pair open
    {3'd3, 16'h0000, 16'h0B00, 3'b100, 1'b1, 16'h140F, 4'h0}, // R6 upper pair shut
    {3'd3, 16'h0000, 16'h0F00, 3'b100, 1'b1, 16'h140F, 4'h0}, // R7
    {3'd2, 16'h1000, 16'h0000, 3'b000, 1'b0, 16'h040F, 4'h0}, // R3
    {3'd3, 16'h0000, 16'h0E00, 3'b100, 1'b0, 16'h040F, 4'h0}, // R7 open
    {3'd4, 16'h0005, 16'h0000, 3'b000, 1'b0, 16'h040F, 4'h5}, // R11
    {3'd3, 16'h0000, 16'h2000, 3'b101, 1'b1, 16'h040F, 4'h5}, // R11
    {3'd3, 16'h0000, 16'h1000, 3'b101, 1'b0, 16'h040F, 4'h5}, // R11
    {3'd5, 16'h0004, 16'h0000, 3'b000, 1'b0, 16'h040F, 4'h1}, // R11
    {3'd3, 16'h0000, 16'h2000, 3'b101, 1'b0, 16'h040F, 4'h1}, // R11
    {3'd3, 16'h0000, 16'h0000, 3'b101, 1'b1, 16'h040F, 4'h1}, // R11
    {3'd3, 16'h0000, 16'h0200, 3'b100, 1'b1, 16'h040F, 4'h1}  // R5 R8
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checkCnt++;
    if (act !== exp) begin
      failCnt++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic idle();
    quadSetWe = 0; quadClrWe = 0; memSetWe = 0; memClrWe = 0;
    quadWdata = '0; memWdata = '0;
    busValid = 0; busWrite = 0; busPriv = 0; busMem = 0; busAddr = '0;
  endtask

  task automatic finishRun();
    $display("End of test - %0d assertions evaluated, %0d failures", checkCnt, failCnt);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failCnt++;
    $display("FAIL watchdog actual=running expected=done");
    finishRun();
  end

  initial begin
    idle();
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 quadProt", 32'(quadProt), 0);
    check("R1 memProt", 32'(memProt), 0);
    check("R1 abort", 32'(abortPulse), 0);
    check("R1 faultAddr", 32'(faultAddr), 0);
    rstN = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      logic [58:0] v;
      v = VEC[i];
      idle();
      case (v[58:56])
        3'd1: begin quadSetWe = 1; quadWdata = v[55:40]; end
        3'd2: begin quadClrWe = 1; quadWdata = v[55:40]; end
        3'd3: begin
          busValid = 1; busAddr = v[39:24];
          busWrite = v[23]; busPriv = v[22]; busMem = v[21];
        end
        3'd4: begin memSetWe = 1; memWdata = v[43:40]; end
        3'd5: begin memClrWe = 1; memWdata = v[43:40]; end
        default: ;
      endcase
      @(negedge clk);
      check($sformatf("R8/R9 vector %0d abort", i), 32'(abortPulse), 32'(v[20]));
      check($sformatf("R2/R3 vector %0d quadProt", i), 32'(quadProt), 32'(v[19:4]));
      check($sformatf("R11 vector %0d memProt", i), 32'(memProt), 32'(v[3:0]));
    end
    idle();

    // R10 address of last violation captured
    check("R10 faultAddr", 32'(faultAddr), 32'h0200);

    // R10 held through allowed privileged write
    busValid = 1; busWrite = 1; busPriv = 1; busAddr = 16'h0300;
    @(negedge clk);
    idle();
    check("R9 priv abort", 32'(abortPulse), 0);
    check("R10 faultAddr hold", 32'(faultAddr), 32'h0200);

    // R3 clear wins over set in the same cycle
    quadSetWe = 1; quadClrWe = 1; quadWdata = 16'h0001;
    @(negedge clk);
    idle();
    check("R3 clear priority", 32'(quadProt), 32'h040E);

    // R8 back-to-back violations give one pulse per request, then low
    busValid = 1; busWrite = 1; busAddr = 16'h0100;
    @(negedge clk);
    check("R8 first pulse", 32'(abortPulse), 1);
    idle();
    @(negedge clk);
    check("R8 pulse ends", 32'(abortPulse), 0);
    check("R10 new faultAddr", 32'(faultAddr), 32'h0100);

    // R1 reset mid-run
    rstN = 1'b0;
    repeat (2) @(negedge clk);
    check("R1 quadProt after reset", 32'(quadProt), 0);
    check("R1 memProt after reset", 32'(memProt), 0);
    check("R1 faultAddr after reset", 32'(faultAddr), 0);
    rstN = 1'b1;
    @(negedge clk);
    finishRun();
  end

endmodule